// File: doc/BRIEF.md
# Loss-of-Clock Bus Cycle Terminator

This block guards a host processor bus against hangs caused by stalled data-path clocks. Two externally supplied clocks, the transmit input clock and the receive line clock, are watched from a free-running local timing clock that does not depend on either of them. Each watched clock is brought into the local domain and checked for toggling. When one has shown no transition for a parameterised number of local cycles, it is flagged as lost.

When a clock is flagged as lost while the host has a read or write cycle open, the block drives a forced ready/acknowledge. The host cycle then completes instead of waiting for logic that will never answer. The ready is held only while the select and strobe stay active, and it drops once the strobe goes away.

An 8-bit control register holds the enable for this protection in its most significant bit. The protection is on after reset. The other bits of the register are stored and presented on the control output for neighbouring logic.

Top module: `clkloss_ready_guard`

## Requirements
- R1: After reset the control byte reads 0xA0 (bit 7 protection enable = 1, bit 5 = 1, all other bits 0). Both lost flags and the forced ready are 0.
- R2: A clock is declared lost after LOSS_LIMIT (default 32) local cycles pass with no detected transition on it. A clock that stopped fewer than 24 local cycles ago is not flagged.
- R3: The two clocks are monitored independently. A stopped transmit clock does not flag the running receive clock, and the reverse also holds.
- R4: A lost flag clears within a few local cycles of a new transition being seen on that clock.
- R5: With protection enabled, any clock lost, select high and read or write strobe high, the forced ready goes to 1 on the next local clock edge.
- R6: The forced ready stays 0 when select is low or when neither strobe is high, even if a clock is lost.
- R7: The forced ready returns to 0 on the first local clock edge after the strobes or the select deassert.
- R8: With control bit 7 written to 0, the forced ready stays 0 while the lost flags still report. Writing bit 7 back to 1 restores the override.
- R9: A configuration write to address 0x01 stores all 8 data bits into the control byte. A write to any other address leaves the control byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Free-running local timing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_clk_in | input | 1 | Monitored transmit input clock |
| rx_clk_in | input | 1 | Monitored receive line clock |
| bus_sel | input | 1 | Host chip select, active high |
| bus_rd | input | 1 | Host read strobe, active high |
| bus_wr | input | 1 | Host write strobe, active high |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 8 | Configuration write address |
| cfg_wdata | input | 8 | Configuration write data |
| ctrl_byte | output | 8 | Current control register contents |
| tx_clk_lost | output | 1 | Transmit clock declared lost |
| rx_clk_lost | output | 1 | Receive clock declared lost |
| bus_ready_force | output | 1 | Forced ready for the open host cycle |

## Verification
The assertions assume that reset is applied before the first local clock edge. They also assume the host strobes and configuration inputs are stable around the local clock edge. The bench meets this by changing every input, including the monitored clocks, only on the falling edge of the local clock. It toggles the monitored clocks every three local cycles, which is well inside the loss window. Each clock stops for either clearly less than or clearly more than the window, so each flag is known when it is sampled, even with the synchroniser delay.

// File: rtl/clkloss_pkg.sv
package clkloss_pkg;
    localparam int unsigned NUM_MON      = 2;
    localparam int unsigned MON_TX       = 0;
    localparam int unsigned MON_RX       = 1;
    localparam logic [7:0]  CTRL_ADDR    = 8'h01;
    localparam logic [7:0]  CTRL_RESET   = 8'hA0;
    localparam int unsigned CTRL_EN_BIT  = 7;
endpackage

// File: rtl/clk_activity_mon.sv
module clk_activity_mon #(
    parameter int unsigned LOSS_LIMIT = 32,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic mon_clk,
    output logic lost_o
);
    localparam int unsigned CNT_W = $clog2(LOSS_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LOSS_LIMIT);

    typedef struct packed {
        logic [SYNC_DEPTH-1:0] sync;
        logic                  prev;
        logic [CNT_W-1:0]      cnt;
    } mon_state_t;

    mon_state_t st_d, st_q;
    logic       edge_seen;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_DEPTH-2:0], mon_clk};
        st_d.prev = st_q.sync[SYNC_DEPTH-1];
        edge_seen = st_q.sync[SYNC_DEPTH-1] ^ st_q.prev;
        if (edge_seen) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LIMIT_V) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lost_o = (st_q.cnt == LIMIT_V);

    // R2
    no_overflow_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        st_q.cnt <= LIMIT_V);
    // R2
    loss_needs_silence_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        $rose(lost_o) |-> !$past(edge_seen));
    // R4
    edge_clears_loss_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        edge_seen |=> !lost_o);
endmodule

// File: rtl/ctrl_reg.sv
module ctrl_reg
    import clkloss_pkg::*;
(
    input  logic       osc_clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_addr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] ctrl_o,
    output logic       prot_en_o
);
    typedef struct packed {
        logic [7:0] ctrl;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we && (cfg_addr == CTRL_ADDR)) st_d.ctrl = cfg_wdata;
    end

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) st_q.ctrl <= CTRL_RESET;
        else        st_q      <= st_d;
    end

    assign ctrl_o    = st_q.ctrl;
    assign prot_en_o = st_q.ctrl[CTRL_EN_BIT];

    // R9
    foreign_addr_ignored_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (cfg_we && cfg_addr != CTRL_ADDR) |=> $stable(ctrl_o));
    // R9
    idle_hold_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !cfg_we |=> $stable(ctrl_o));
endmodule

// File: rtl/ready_override.sv
module ready_override
    import clkloss_pkg::*;
(
    input  logic               osc_clk,
    input  logic               rst_n,
    input  logic               prot_en,
    input  logic [NUM_MON-1:0] lost,
    input  logic               bus_sel,
    input  logic               bus_rd,
    input  logic               bus_wr,
    output logic               ready_o
);
    typedef struct packed {
        logic ready;
    } rdy_state_t;

    rdy_state_t st_d, st_q;
    logic       cycle_open;

    always_comb begin
        cycle_open = bus_sel && (bus_rd || bus_wr);
        st_d       = st_q;
        st_d.ready = prot_en && (|lost) && cycle_open;
    end

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready_o = st_q.ready;

    // R7
    release_on_close_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !cycle_open |=> !ready_o);
    // R8
    disabled_no_force_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !prot_en |=> !ready_o);
    // R6
    needs_loss_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (lost == '0) |=> !ready_o);
endmodule

// File: rtl/clkloss_ready_guard.sv
module clkloss_ready_guard
    import clkloss_pkg::*;
#(
    parameter int unsigned LOSS_LIMIT = 32,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic       osc_clk,
    input  logic       rst_n,
    input  logic       tx_clk_in,
    input  logic       rx_clk_in,
    input  logic       bus_sel,
    input  logic       bus_rd,
    input  logic       bus_wr,
    input  logic       cfg_we,
    input  logic [7:0] cfg_addr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] ctrl_byte,
    output logic       tx_clk_lost,
    output logic       rx_clk_lost,
    output logic       bus_ready_force
);
    logic [NUM_MON-1:0] watched;
    logic [NUM_MON-1:0] lost_vec;
    logic               prot_en;

    assign watched[MON_TX] = tx_clk_in;
    assign watched[MON_RX] = rx_clk_in;

    for (genvar g = 0; g < NUM_MON; g++) begin : g_mon
        clk_activity_mon #(
            .LOSS_LIMIT (LOSS_LIMIT),
            .SYNC_DEPTH (SYNC_DEPTH)
        ) mon_i (
            .osc_clk (osc_clk),
            .rst_n   (rst_n),
            .mon_clk (watched[g]),
            .lost_o  (lost_vec[g])
        );
    end

    ctrl_reg ctrl_i (
        .osc_clk   (osc_clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ctrl_o    (ctrl_byte),
        .prot_en_o (prot_en)
    );

    ready_override rdy_i (
        .osc_clk (osc_clk),
        .rst_n   (rst_n),
        .prot_en (prot_en),
        .lost    (lost_vec),
        .bus_sel (bus_sel),
        .bus_rd  (bus_rd),
        .bus_wr  (bus_wr),
        .ready_o (bus_ready_force)
    );

    assign tx_clk_lost = lost_vec[MON_TX];
    assign rx_clk_lost = lost_vec[MON_RX];

    // R5
    force_follows_open_cycle_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
        bus_ready_force |-> $past(bus_sel));
endmodule

// File: tb/clkloss_ready_guard_tb.sv
`timescale 1ns/1ps
module clkloss_ready_guard_tb_top;
    logic       osc_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_clk_in = 1'b0;
    logic       rx_clk_in = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_addr = 8'h00;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] ctrl_byte;
    logic       tx_clk_lost;
    logic       rx_clk_lost;
    logic       bus_ready_force;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string      tag;
        logic [10:0] expv;
        logic [10:0] mask;
    } item_t;
    item_t sb_q[$];

    always #2.5 osc_clk = ~osc_clk;

    clkloss_ready_guard dut_i (
        .osc_clk (osc_clk), .rst_n (rst_n),
        .tx_clk_in (tx_clk_in), .rx_clk_in (rx_clk_in),
        .bus_sel (bus_sel), .bus_rd (bus_rd), .bus_wr (bus_wr),
        .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata),
        .ctrl_byte (ctrl_byte), .tx_clk_lost (tx_clk_lost),
        .rx_clk_lost (rx_clk_lost), .bus_ready_force (bus_ready_force)
    );

    // observed vector: {ready, rx_lost, tx_lost, ctrl[7:0]}
    localparam logic [10:0] M_RDY  = 11'h400;
    localparam logic [10:0] M_RX   = 11'h200;
    localparam logic [10:0] M_TX   = 11'h100;
    localparam logic [10:0] M_CTRL = 11'h0FF;

    // monitor: pops one expected item per falling edge and compares
    always @(negedge osc_clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            logic [10:0] obs;
            it  = sb_q.pop_front();
            obs = {bus_ready_force, rx_clk_lost, tx_clk_lost, ctrl_byte};
            checks++;
            if ((obs & it.mask) !== (it.expv & it.mask)) begin
                errors++;
                $display("FAIL %s: actual=%h expected=%h (mask %h)",
                         it.tag, obs & it.mask, it.expv & it.mask, it.mask);
            end
        end
    end

    // driver side: push expectation, monitor samples at the next falling edge
    task automatic expect_now(input string tag, input logic [10:0] e, input logic [10:0] m);
        @(posedge osc_clk);
        sb_q.push_back('{tag, e, m});
        @(negedge osc_clk);
    endtask

    // run n local cycles, toggling running clocks every third cycle
    task automatic run(input int n, input bit tx_run, input bit rx_run);
        for (int i = 0; i < n; i++) begin
            @(negedge osc_clk);
            if (i % 3 == 0) begin
                if (tx_run) tx_clk_in = ~tx_clk_in;
                if (rx_run) rx_clk_in = ~rx_clk_in;
            end
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge osc_clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge osc_clk);
        cfg_we = 1'b0;
    endtask

    task automatic strobe(input bit s, input bit r, input bit w);
        @(negedge osc_clk);
        bus_sel = s; bus_rd = r; bus_wr = w;
    endtask

    initial begin
        run(4, 1, 1);
        rst_n = 1'b1;
        run(10, 1, 1);
        // R1 reset state
        expect_now("R1 reset state", {1'b0, 1'b0, 1'b0, 8'hA0}, M_RDY | M_RX | M_TX | M_CTRL);

        // R2 early: tx stopped for ~20 cycles is not lost
        run(20, 0, 1);
        expect_now("R2 not lost before window", 11'h000, M_TX);
        run(25, 0, 1);
        expect_now("R2 tx lost after window", M_TX, M_TX);
        expect_now("R3 rx unaffected by tx loss", 11'h000, M_RX);

        // R6 no strobe
        expect_now("R6 no forced ready without cycle", 11'h000, M_RDY);
        strobe(1, 1, 0);
        run(2, 0, 1);
        expect_now("R5 forced ready on read", M_RDY, M_RDY);
        strobe(1, 0, 0);
        run(1, 0, 1);
        expect_now("R7 release after strobe drop", 11'h000, M_RDY);
        strobe(1, 0, 1);
        run(1, 0, 1);
        expect_now("R5 forced ready on write", M_RDY, M_RDY);
        strobe(0, 0, 1);
        run(1, 0, 1);
        expect_now("R7 release after select drop", 11'h000, M_RDY);
        strobe(0, 1, 0);
        run(2, 0, 1);
        expect_now("R6 read without select", 11'h000, M_RDY);

        // R4 resume tx
        strobe(0, 0, 0);
        run(9, 1, 1);
        expect_now("R4 tx flag cleared on resume", 11'h000, M_TX);
        strobe(1, 1, 0);
        run(2, 1, 1);
        expect_now("R5 no forced ready when clocks alive", 11'h000, M_RDY);
        strobe(0, 0, 0);

        // R3 rx stops alone
        run(45, 1, 0);
        expect_now("R3 rx lost, tx alive", M_RX, M_RX | M_TX);

        // both stopped
        run(45, 0, 0);
        expect_now("R2 both lost", M_RX | M_TX, M_RX | M_TX);

        // R9 writes
        cfg_write(8'h02, 8'h00);
        expect_now("R9 foreign address ignored", {3'b000, 8'hA0}, M_CTRL);
        cfg_write(8'h01, 8'h5F);
        expect_now("R9 full byte stored", {3'b000, 8'h5F}, M_CTRL);

        // R8 disabled
        strobe(1, 1, 0);
        run(2, 0, 0);
        expect_now("R8 no force when disabled", 11'h000, M_RDY);
        expect_now("R8 flags still report", M_RX | M_TX, M_RX | M_TX);
        cfg_write(8'h01, 8'h80);
        run(2, 0, 0);
        expect_now("R8 re-enabled force", M_RDY, M_RDY);
        strobe(0, 0, 0);
        run(2, 0, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule